// File: doc/BRIEF.md
# Thermal Trip Monitor

This block watches a digital temperature code that arrives from an on-die sensor together with a sample-valid strobe. It checks each valid sample against two programmable limits. The higher-severity limit guards the silicon: once it is enabled and a sample reaches it, the block pulls its clock-enable output low in that same cycle. It then holds the output low until reset, even if the temperature falls again. The lower limit is a warning level. When it is enabled and the interrupt command bit is set, a rising crossing produces a one-cycle interrupt request and sets a sticky alert flag. Firmware can read that flag later to confirm why the interrupt arrived.

The warning path has hysteresis. After it fires, it stays quiet until a valid sample lands strictly below the warning limit minus a programmable hysteresis amount. A simple synchronous register port sets the two limits, the hysteresis amount, the enables and the command bit. The same port reads the status and clears the alert by writing 1 to it.

Top module: `thermal_trip_monitor`

## Requirements
- R1: After reset, clk_en is 1 and smi_req is 0. The control word (address 3) reads 0 and the status word (address 4) reads 0. Both limit registers (addresses 0 and 1) read all ones, and the hysteresis register (address 2) reads 0.
- R2: When the shutdown enable (control bit 0) is 1 and a valid sample is greater than or equal to the shutdown limit, clk_en is 0 in the same cycle as that sample.
- R3: Once a shutdown has occurred, clk_en stays 0 until reset, whatever later samples arrive, and status bit 1 reads 1.
- R4: With control bit 0 clear, samples at or above the shutdown limit leave clk_en at 1.
- R5: With the warning enable (control bit 1) and the command bit (control bit 2) both set, a valid sample that moves from the armed state to at-or-above the warning limit drives smi_req high for exactly the one cycle after the sampling edge.
- R6: After a warning event, no further smi_req occurs until a valid sample satisfies sample + hysteresis < warning limit. A sample exactly at limit minus hysteresis does not re-arm the warning.
- R7: If either control bit 1 or control bit 2 is 0, a warning crossing raises no smi_req and does not set the alert. While control bit 1 is 0, the warning detector is held armed.
- R8: Status bit 0 (alert) is set together with each smi_req. It stays set until a write to address 4 with data bit 0 equal to 1, and writing 0 there leaves it set.
- R9: If an alert-clearing write and a new warning event fall on the same edge, the alert ends up set.
- R10: A sample is used only on cycles with temp_valid high; temp_code is ignored on all other cycles.
- R11: A read with reg_re high presents the addressed register on reg_rdata after the next clock edge and holds it there until the next read. Writes with reg_we high take effect at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_valid | input | 1 | temp_code holds a fresh sample this cycle |
| temp_code | input | TEMP_W | Temperature sample code, larger is hotter |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| clk_en | output | 1 | Clock enable for the rest of the die, 0 stops all clocks |
| smi_req | output | 1 | One-cycle interrupt request from the warning limit |

## Verification
The checker covers several behaviours on every cycle:
- a qualifying shutdown sample always coincides with clk_en low;
- clk_en never returns high once it has fallen;
- smi_req never lasts two cycles and never follows a cycle without a valid sample;
- the alert never drops unless a clearing write occurred, and never rises without a matching interrupt.

Some behaviours only the scenarios can show:
- the exact hysteresis re-arm boundary;
- the gating by the enable and command bits;
- the set-over-clear collision;
- the register readback values after reset and after a shutdown.

// File: rtl/ttm_pkg.sv
package ttm_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CAT_LIMIT = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_HOT_LIMIT = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_HYST      = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL      = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_STATUS    = 3'd4;

    localparam int CTRL_CAT_EN = 0;
    localparam int CTRL_HOT_EN = 1;
    localparam int CTRL_CMD    = 2;
    localparam int STAT_ALERT  = 0;
    localparam int STAT_CAT    = 1;
endpackage

// File: rtl/ttm_regfile.sv
module ttm_regfile
    import ttm_pkg::*;
#(
    parameter int TEMP_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              alert_set,
    input  logic              cat_tripped,
    output logic [TEMP_W-1:0] cat_limit,
    output logic [TEMP_W-1:0] hot_limit,
    output logic [TEMP_W-1:0] hyst,
    output logic              cat_en,
    output logic              hot_en,
    output logic              smi_cmd,
    output logic              alert,
    output logic [DATA_W-1:0] reg_rdata
);
    typedef struct packed {
        logic [TEMP_W-1:0] cat_limit;
        logic [TEMP_W-1:0] hot_limit;
        logic [TEMP_W-1:0] hyst;
        logic              cat_en;
        logic              hot_en;
        logic              smi_cmd;
        logic              alert;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  alert_clr;
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        regs_d    = regs_q;
        alert_clr = reg_we && (reg_addr == ADDR_STATUS) && reg_wdata[STAT_ALERT];

        if (reg_we) begin
            case (reg_addr)
                ADDR_CAT_LIMIT: regs_d.cat_limit = reg_wdata[TEMP_W-1:0];
                ADDR_HOT_LIMIT: regs_d.hot_limit = reg_wdata[TEMP_W-1:0];
                ADDR_HYST:      regs_d.hyst      = reg_wdata[TEMP_W-1:0];
                ADDR_CTRL: begin
                    regs_d.cat_en  = reg_wdata[CTRL_CAT_EN];
                    regs_d.hot_en  = reg_wdata[CTRL_HOT_EN];
                    regs_d.smi_cmd = reg_wdata[CTRL_CMD];
                end
                default: ;
            endcase
        end

        // a new event wins over a clear on the same edge
        regs_d.alert = alert_set | (regs_q.alert & ~alert_clr);

        rd_word = '0;
        case (reg_addr)
            ADDR_CAT_LIMIT: rd_word[TEMP_W-1:0] = regs_q.cat_limit;
            ADDR_HOT_LIMIT: rd_word[TEMP_W-1:0] = regs_q.hot_limit;
            ADDR_HYST:      rd_word[TEMP_W-1:0] = regs_q.hyst;
            ADDR_CTRL: begin
                rd_word[CTRL_CAT_EN] = regs_q.cat_en;
                rd_word[CTRL_HOT_EN] = regs_q.hot_en;
                rd_word[CTRL_CMD]    = regs_q.smi_cmd;
            end
            ADDR_STATUS: begin
                rd_word[STAT_ALERT] = regs_q.alert;
                rd_word[STAT_CAT]   = cat_tripped;
            end
            default: ;
        endcase
        if (reg_re) begin
            regs_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q           <= '0;
            regs_q.cat_limit <= '1;
            regs_q.hot_limit <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cat_limit = regs_q.cat_limit;
    assign hot_limit = regs_q.hot_limit;
    assign hyst      = regs_q.hyst;
    assign cat_en    = regs_q.cat_en;
    assign hot_en    = regs_q.hot_en;
    assign smi_cmd   = regs_q.smi_cmd;
    assign alert     = regs_q.alert;
    assign reg_rdata = regs_q.rdata;
endmodule

// File: rtl/ttm_cat_guard.sv
module ttm_cat_guard #(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_valid,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [TEMP_W-1:0] cat_limit,
    input  logic              cat_en,
    output logic              clk_en,
    output logic              tripped
);
    typedef struct packed {
        logic tripped;
    } guard_t;

    guard_t g_d, g_q;
    logic   hit;

    always_comb begin
        g_d        = g_q;
        hit        = temp_valid && cat_en && (temp_code >= cat_limit);
        g_d.tripped = g_q.tripped | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    // combinational drop so shutdown does not wait for an edge
    assign clk_en  = ~(g_q.tripped | hit);
    assign tripped = g_q.tripped;
endmodule

// File: rtl/ttm_hot_detect.sv
module ttm_hot_detect #(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_valid,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [TEMP_W-1:0] hot_limit,
    input  logic [TEMP_W-1:0] hyst,
    input  logic              hot_en,
    input  logic              smi_cmd,
    output logic              smi_req,
    output logic              alert_set
);
    localparam int SUM_W = TEMP_W + 1;

    typedef struct packed {
        logic armed;
        logic smi;
    } hot_t;

    hot_t h_d, h_q;
    logic at_or_above;
    logic below_band;
    logic crossing;
    logic [SUM_W-1:0] band_sum;

    always_comb begin
        h_d         = h_q;
        at_or_above = temp_code >= hot_limit;
        band_sum    = {1'b0, temp_code} + {1'b0, hyst};
        below_band  = band_sum < {1'b0, hot_limit};
        crossing    = temp_valid && hot_en && h_q.armed && at_or_above;

        h_d.smi = crossing && smi_cmd;

        if (!hot_en) begin
            h_d.armed = 1'b1;
        end else if (temp_valid) begin
            if (crossing) begin
                h_d.armed = 1'b0;
            end else if (!h_q.armed && below_band) begin
                h_d.armed = 1'b1;
            end
        end

        alert_set = crossing && smi_cmd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q       <= '0;
            h_q.armed <= 1'b1;
        end else begin
            h_q <= h_d;
        end
    end

    assign smi_req = h_q.smi;
endmodule

// File: rtl/thermal_trip_monitor.sv
module thermal_trip_monitor
    import ttm_pkg::*;
#(
    parameter int TEMP_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_valid,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_en,
    output logic              smi_req
);
    logic [TEMP_W-1:0] cat_limit_w;
    logic [TEMP_W-1:0] hot_limit_w;
    logic [TEMP_W-1:0] hyst_w;
    logic              cat_en_w;
    logic              hot_en_w;
    logic              smi_cmd_w;
    logic              alert_w;
    logic              alert_set_w;
    logic              tripped_w;

    ttm_regfile #(.TEMP_W(TEMP_W), .DATA_W(DATA_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_re      (reg_re),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .alert_set   (alert_set_w),
        .cat_tripped (tripped_w),
        .cat_limit   (cat_limit_w),
        .hot_limit   (hot_limit_w),
        .hyst        (hyst_w),
        .cat_en      (cat_en_w),
        .hot_en      (hot_en_w),
        .smi_cmd     (smi_cmd_w),
        .alert       (alert_w),
        .reg_rdata   (reg_rdata)
    );

    ttm_cat_guard #(.TEMP_W(TEMP_W)) cat_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_valid (temp_valid),
        .temp_code  (temp_code),
        .cat_limit  (cat_limit_w),
        .cat_en     (cat_en_w),
        .clk_en     (clk_en),
        .tripped    (tripped_w)
    );

    ttm_hot_detect #(.TEMP_W(TEMP_W)) hot_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_valid (temp_valid),
        .temp_code  (temp_code),
        .hot_limit  (hot_limit_w),
        .hyst       (hyst_w),
        .hot_en     (hot_en_w),
        .smi_cmd    (smi_cmd_w),
        .smi_req    (smi_req),
        .alert_set  (alert_set_w)
    );
endmodule

// File: rtl/ttm_chk.sv
module ttm_chk #(
    parameter int TEMP_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              temp_valid,
    input logic [TEMP_W-1:0] temp_code,
    input logic              reg_we,
    input logic [2:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              clk_en,
    input logic              smi_req,
    input logic              cat_en,
    input logic [TEMP_W-1:0] cat_limit,
    input logic              alert
);
    logic clearing;
    assign clearing = reg_we && (reg_addr == 3'd4) && reg_wdata[0];

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_state_chk: assert (clk_en && !smi_req);
        end
    end

    // R2
    shutdown_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_valid && cat_en && (temp_code >= cat_limit)) |-> !clk_en);

    // R3
    shutdown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> !clk_en);

    // R5
    smi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |=> !smi_req);

    // R10
    smi_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_valid |=> !smi_req);

    // R8
    alert_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alert && !clearing) |=> alert);

    // R8
    alert_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert) |-> smi_req);
endmodule

bind thermal_trip_monitor ttm_chk #(.TEMP_W(TEMP_W), .DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .temp_valid (temp_valid),
    .temp_code  (temp_code),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .clk_en     (clk_en),
    .smi_req    (smi_req),
    .cat_en     (cat_en_w),
    .cat_limit  (cat_limit_w),
    .alert      (alert_w)
);

// File: tb/thermal_trip_monitor_tb_top.sv
module thermal_trip_monitor_tb_top;
    localparam int TEMP_W = 8;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              temp_valid = 1'b0;
    logic [TEMP_W-1:0] temp_code = '0;
    logic              reg_we = 1'b0;
    logic              reg_re = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              clk_en;
    logic              smi_req;

    always #10 clk = ~clk;

    thermal_trip_monitor #(.TEMP_W(TEMP_W), .DATA_W(DATA_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_valid (temp_valid),
        .temp_code  (temp_code),
        .reg_we     (reg_we),
        .reg_re     (reg_re),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .clk_en     (clk_en),
        .smi_req    (smi_req)
    );

    typedef struct {
        logic  smi;
        logic  en;
        string req;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [2:0] a, logic [DATA_W-1:0] d);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [DATA_W-1:0] d);
        @(posedge clk); #2;
        reg_re = 1'b1; reg_addr = a;
        @(posedge clk); #2;
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    // driver: one valid sample, pushes the expected result for the monitor
    task automatic sample(logic [TEMP_W-1:0] t, logic exp_smi, logic en_now,
                          logic en_after, string req);
        @(posedge clk); #2;
        temp_valid = 1'b1; temp_code = t;
        #2;
        check({req, " clk_en same cycle"}, clk_en, en_now);
        @(posedge clk);
        sb_q.push_back('{smi: exp_smi, en: en_after, req: req});
        #2;
        temp_valid = 1'b0;
    endtask

    task automatic sample_with_clear(logic [TEMP_W-1:0] t, logic exp_smi, string req);
        @(posedge clk); #2;
        temp_valid = 1'b1; temp_code = t;
        reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h01;
        @(posedge clk);
        sb_q.push_back('{smi: exp_smi, en: 1'b1, req: req});
        #2;
        temp_valid = 1'b0; reg_we = 1'b0;
    endtask

    // monitor: pops expected items after each sampling edge, else expects no request
    always @(posedge clk) begin
        #6;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.req, " smi_req"}, smi_req, e.smi);
            check({e.req, " clk_en after"}, clk_en, e.en);
        end else if (smi_req !== 1'b0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R5/R10 unexpected smi_req actual=%0b expected=0", smi_req);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] rd;

        // R1 reset state
        repeat (3) @(posedge clk);
        #2;
        check("R1 clk_en in reset", clk_en, 1'b1);
        check("R1 smi_req in reset", smi_req, 1'b0);
        rst_n = 1'b1;
        reg_read(3'd3, rd); check("R1 ctrl reads 0", rd, 8'h00);
        reg_read(3'd4, rd); check("R1 status reads 0", rd, 8'h00);
        reg_read(3'd0, rd); check("R1 shutdown limit reads ff", rd, 8'hff);
        reg_read(3'd2, rd); check("R1 hysteresis reads 0", rd, 8'h00);

        // R11 write then read back
        reg_write(3'd1, 8'd100);
        reg_write(3'd2, 8'd10);
        reg_read(3'd1, rd); check("R11 warning limit readback", rd, 8'd100);
        reg_read(3'd2, rd); check("R11 hysteresis readback", rd, 8'd10);

        // R5 and R6 warning crossings with hysteresis
        reg_write(3'd3, 8'h06);
        sample(8'd90,  1'b0, 1'b1, 1'b1, "R5 below limit");
        sample(8'd100, 1'b1, 1'b1, 1'b1, "R5 crossing at limit");
        sample(8'd105, 1'b0, 1'b1, 1'b1, "R6 still above");
        sample(8'd95,  1'b0, 1'b1, 1'b1, "R6 inside band");
        sample(8'd90,  1'b0, 1'b1, 1'b1, "R6 band edge no rearm");
        sample(8'd100, 1'b0, 1'b1, 1'b1, "R6 not rearmed");
        sample(8'd89,  1'b0, 1'b1, 1'b1, "R6 rearm sample");
        sample(8'd100, 1'b1, 1'b1, 1'b1, "R6 second crossing");

        // R8 sticky alert, write-one-to-clear
        reg_read(3'd4, rd); check("R8 alert set", rd, 8'h01);
        reg_write(3'd4, 8'h00);
        reg_read(3'd4, rd); check("R8 write 0 keeps alert", rd, 8'h01);
        reg_write(3'd4, 8'h01);
        reg_read(3'd4, rd); check("R8 write 1 clears alert", rd, 8'h00);

        // R10 samples ignored without temp_valid
        sample(8'd50, 1'b0, 1'b1, 1'b1, "R10 rearm");
        @(posedge clk); #2;
        temp_code = 8'd120;
        repeat (4) @(posedge clk);
        #2;
        temp_code = 8'd0;
        reg_read(3'd4, rd); check("R10 no alert without valid", rd, 8'h00);

        // R7 gating by enable and command
        reg_write(3'd3, 8'h02);
        sample(8'd120, 1'b0, 1'b1, 1'b1, "R7 command clear");
        reg_read(3'd4, rd); check("R7 no alert command clear", rd, 8'h00);
        sample(8'd50, 1'b0, 1'b1, 1'b1, "R7 rearm");
        reg_write(3'd3, 8'h04);
        sample(8'd120, 1'b0, 1'b1, 1'b1, "R7 warning disabled");
        reg_read(3'd4, rd); check("R7 no alert warning disabled", rd, 8'h00);

        // R9 set beats clear
        reg_write(3'd3, 8'h06);
        sample(8'd50, 1'b0, 1'b1, 1'b1, "R9 armed");
        sample_with_clear(8'd120, 1'b1, "R9 collision");
        reg_read(3'd4, rd); check("R9 alert survives clear", rd, 8'h01);
        reg_write(3'd4, 8'h01);

        // R4 shutdown disabled
        reg_write(3'd0, 8'd80);
        reg_write(3'd3, 8'h00);
        sample(8'd120, 1'b0, 1'b1, 1'b1, "R4 shutdown disabled");

        // R2 shutdown in the same cycle
        reg_write(3'd3, 8'h01);
        sample(8'd70, 1'b0, 1'b1, 1'b1, "R2 below shutdown");
        sample(8'd80, 1'b0, 1'b0, 1'b0, "R2 equal to shutdown");

        // R3 latched until reset
        sample(8'd20, 1'b0, 1'b0, 1'b0, "R3 cooled sample");
        reg_read(3'd4, rd); check("R3 status shutdown bit", rd, 8'h02);
        repeat (3) @(posedge clk);
        #2;
        check("R3 clk_en held low", clk_en, 1'b0);

        // R1 reset releases shutdown
        rst_n = 1'b0;
        #2;
        check("R1 clk_en after reset", clk_en, 1'b1);
        repeat (2) @(posedge clk);
        #2;
        rst_n = 1'b1;
        reg_read(3'd3, rd); check("R1 ctrl after second reset", rd, 8'h00);

        repeat (3) @(posedge clk);
        #8;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule